// File: doc/BRIEF.md
# Accumulator CPU Core

This block is a small stored-program processor with a single 16-bit accumulator as its only data register. Hardwired control steps each instruction through a fetch phase, a decode phase, an optional operand read and an execute phase. Each phase takes one or more clock cycles. All memory traffic goes through an address register and a buffer register. These drive a synchronous 4096-word by 16-bit memory that sits outside the core and returns read data one cycle after the address.

An instruction word carries a 4-bit opcode in bits 15:12 and a 12-bit direct word address in bits 11:0. The instruction set covers:

- load, store, add and subtract;
- clearing the accumulator;
- an unconditional jump;
- a conditional skip of the next instruction;
- an add through a pointer and a jump through a pointer;
- a jump that first saves the return address;
- byte input and byte output, each with a valid/ready handshake;
- halt.

A single maskable interrupt request is examined only between instructions. Taking it saves the program counter in word 0x000 and enters a handler at word 0x001. The handler returns with a pointer jump through word 0x000, which also re-enables interrupts. After reset, execution starts at a parameter address, 0x010 by default.

Top module: `acc_cpu`

## Requirements
- R1: During and after reset, `halt`, `mem_we`, `out_valid` and `in_ready` are low, interrupts are enabled, and the first instruction is fetched from address RESET_VEC (default 0x010).
- R2: Opcodes 0x1 (load), 0x3 (add) and 0x4 (subtract) operate on the word at the 12-bit address in bits 11:0, with 16-bit two's-complement wrap-around (0x0023 + 0xFFE9 = 0x000C). Opcode 0x2 stores the accumulator at that address.
- R3: A memory write is a single-cycle pulse on `mem_we`, with `mem_addr` and `mem_wdata` valid in that cycle. Reads return `mem_rdata` one cycle after the address.
- R4: Opcode 0x8 skips the next instruction when a condition holds; the condition is chosen by bits 11:10. 00 tests for a negative accumulator, 01 for zero, and 10 for positive (non-negative and non-zero). 11 never skips.
- R5: Opcode 0x9 loads the program counter with bits 11:0. Opcode 0xA sets the accumulator to zero.
- R6: Opcode 0x0 writes the address of the following instruction into word X and continues at X+1. Opcode 0xC continues at the low 12 bits of word X.
- R7: Opcode 0xB adds to the accumulator the word whose address is held in the low 12 bits of word X.
- R8: Opcode 0x5 raises `in_ready` and waits for `in_valid`. It then loads the accumulator with the input byte, zero-extended to 16 bits.
- R9: Opcode 0x6 presents the accumulator's low byte on `out_data` with `out_valid` high. Both hold unchanged until `out_ready` is seen.
- R10: Opcode 0x7 raises `halt`, which stays high until reset, and no memory write follows. Opcodes 0xD, 0xE and 0xF change nothing but the program counter.
- R11: An interrupt is taken only at the end of an instruction and only while enabled. Taking it writes the program counter, including any skip just taken, to word 0x000, continues at 0x001 and disables further interrupts. A jump through word 0x000 re-enables them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (buffer register) |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Core waiting for an input byte |
| out_valid | output | 1 | Output byte held for the consumer |
| out_data | output | 8 | Output byte register |
| out_ready | input | 1 | Consumer takes the output byte |
| irq | input | 1 | Level-sensitive maskable interrupt request |
| halt | output | 1 | Core has stopped |

## Verification
The sharpest overlap is between a conditional skip that is taken and an interrupt accepted at the end of that same instruction. The saved word must already include the extra increment. The bench provokes this by holding `irq` high from reset while the first instruction is a zero-test skip that succeeds. It then judges the outcome by the value left in word 0x000.

The request is kept high until the handler's own store is seen, so a second entry would overwrite the saved word. That makes masking inside the handler observable through the same value.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam logic [3:0] OP_JNS   = 4'h0;
  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_ADD   = 4'h3;
  localparam logic [3:0] OP_SUBT  = 4'h4;
  localparam logic [3:0] OP_INPUT = 4'h5;
  localparam logic [3:0] OP_OUTPT = 4'h6;
  localparam logic [3:0] OP_HALT  = 4'h7;
  localparam logic [3:0] OP_SKIP  = 4'h8;
  localparam logic [3:0] OP_JUMP  = 4'h9;
  localparam logic [3:0] OP_CLEAR = 4'hA;
  localparam logic [3:0] OP_ADDI  = 4'hB;
  localparam logic [3:0] OP_JUMPI = 4'hC;

  typedef enum logic [3:0] {
    ST_FA,     // address register <- program counter
    ST_FW,     // memory read in flight
    ST_FB,     // buffer <- memory
    ST_FI,     // instruction register <- buffer, program counter + 1
    ST_DEC,    // decode, address register <- address field
    ST_RA,     // operand read in flight
    ST_RB,     // buffer <- operand
    ST_EXE,    // execute with operand
    ST_WR,     // write strobe cycle
    ST_IN,     // wait for input byte
    ST_INX,    // accumulator <- input register
    ST_OUT,    // wait for output acceptance
    ST_END,    // end of instruction, interrupt check
    ST_HALT    // stopped
  } cpu_state_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end
endmodule

// File: rtl/acc_skip_eval.sv
module acc_skip_eval #(
  parameter int W = 16
) (
  input  logic [W-1:0] ac,
  input  logic [1:0]   sel,
  output logic         take
);
  logic neg, zero;
  always_comb begin
    neg  = ac[W-1];
    zero = (ac == '0);
    case (sel)
      2'b00:   take = neg;
      2'b01:   take = zero;
      2'b10:   take = !neg && !zero;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int          AW        = 12,
  parameter int          DW        = 16,
  parameter int          IOW       = 8,
  parameter logic [11:0] RESET_VEC = 12'h010
) (
  input  logic           clk,
  input  logic           rst,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           in_valid,
  input  logic [IOW-1:0] in_data,
  output logic           in_ready,
  output logic           out_valid,
  output logic [IOW-1:0] out_data,
  input  logic           out_ready,
  input  logic           irq,
  output logic           halt
);
  localparam int OPW = DW - AW;

  cpu_state_t     state;
  logic [AW-1:0]  pc, mar;
  logic [DW-1:0]  ir, mbr, ac;
  logic [IOW-1:0] inreg, outreg;
  logic           ie, ind, we_q, halt_q, oval_q;

  logic [OPW-1:0] op;
  logic [AW-1:0]  fld;
  logic [DW-1:0]  alu_y;
  logic           skip_take;

  assign op   = ir[DW-1:AW];
  assign fld  = ir[AW-1:0];

  acc_alu #(.W(DW)) u_alu (
    .a   (ac),
    .b   (mbr),
    .sub (op == OP_SUBT),
    .y   (alu_y)
  );

  acc_skip_eval #(.W(DW)) u_skip (
    .ac   (ac),
    .sel  (fld[AW-1:AW-2]),
    .take (skip_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FA;
      pc     <= RESET_VEC[AW-1:0];
      mar    <= '0;
      ir     <= '0;
      mbr    <= '0;
      ac     <= '0;
      inreg  <= '0;
      outreg <= '0;
      ie     <= 1'b1;
      ind    <= 1'b0;
      we_q   <= 1'b0;
      halt_q <= 1'b0;
      oval_q <= 1'b0;
    end else begin
      case (state)
        ST_FA: begin
          mar   <= pc;
          state <= ST_FW;
        end
        ST_FW: state <= ST_FB;
        ST_FB: begin
          mbr   <= mem_rdata;
          state <= ST_FI;
        end
        ST_FI: begin
          ir    <= mbr;
          pc    <= pc + 1'b1;
          state <= ST_DEC;
        end
        ST_DEC: begin
          mar <= fld;
          case (op)
            OP_LOAD, OP_ADD, OP_SUBT, OP_ADDI, OP_JUMPI: state <= ST_RA;
            OP_STORE: begin
              mbr   <= ac;
              we_q  <= 1'b1;
              state <= ST_WR;
            end
            OP_JNS: begin
              mbr   <= {{(DW-AW){1'b0}}, pc};
              we_q  <= 1'b1;
              pc    <= fld + 1'b1;
              state <= ST_WR;
            end
            OP_INPUT: state <= ST_IN;
            OP_OUTPT: begin
              outreg <= ac[IOW-1:0];
              oval_q <= 1'b1;
              state  <= ST_OUT;
            end
            OP_HALT: begin
              halt_q <= 1'b1;
              state  <= ST_HALT;
            end
            OP_SKIP: begin
              if (skip_take) pc <= pc + 1'b1;
              state <= ST_END;
            end
            OP_JUMP: begin
              pc    <= fld;
              state <= ST_END;
            end
            OP_CLEAR: begin
              ac    <= '0;
              state <= ST_END;
            end
            default: state <= ST_END;
          endcase
        end
        ST_RA: state <= ST_RB;
        ST_RB: begin
          mbr   <= mem_rdata;
          state <= ST_EXE;
        end
        ST_EXE: begin
          state <= ST_END;
          case (op)
            OP_LOAD:         ac <= mbr;
            OP_ADD, OP_SUBT: ac <= alu_y;
            OP_ADDI: begin
              if (!ind) begin
                mar   <= mbr[AW-1:0];
                ind   <= 1'b1;
                state <= ST_RA;
              end else begin
                ac  <= alu_y;
                ind <= 1'b0;
              end
            end
            OP_JUMPI: begin
              pc <= mbr[AW-1:0];
              if (fld == '0) ie <= 1'b1;
            end
            default: ;
          endcase
        end
        ST_WR: begin
          we_q  <= 1'b0;
          state <= ST_END;
        end
        ST_IN: begin
          if (in_valid) begin
            inreg <= in_data;
            state <= ST_INX;
          end
        end
        ST_INX: begin
          ac    <= {{(DW-IOW){1'b0}}, inreg};
          state <= ST_END;
        end
        ST_OUT: begin
          if (out_ready) begin
            oval_q <= 1'b0;
            state  <= ST_END;
          end
        end
        ST_END: begin
          if (irq && ie) begin
            mbr   <= {{(DW-AW){1'b0}}, pc};
            mar   <= '0;
            we_q  <= 1'b1;
            pc    <= {{(AW-1){1'b0}}, 1'b1};
            ie    <= 1'b0;
            state <= ST_WR;
          end else begin
            state <= ST_FA;
          end
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_FA;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_we    = we_q;
  assign mem_wdata = mbr;
  assign in_ready  = (state == ST_IN);
  assign out_valid = oval_q;
  assign out_data  = outreg;
  assign halt      = halt_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int AW  = 12,
  parameter int IOW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_we,
  input logic           in_ready,
  input logic           out_valid,
  input logic [IOW-1:0] out_data,
  input logic           out_ready,
  input logic           halt
);
  // R10: once stopped, stays stopped
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  // R10: no memory write while stopped
  a_r10_halt_no_write: assert property (@(posedge clk) disable iff (rst)
    halt |-> !mem_we);

  // R3: write strobe lasts one cycle
  a_r3_write_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R9: output byte held until accepted
  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: input wait and output wait never overlap
  a_r8_io_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R10: address frozen while stopped
  a_r10_halt_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (halt && $past(halt)) |-> $stable(mem_addr));
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .IOW(IOW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .halt      (halt)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        irq = 1'b0;
  logic        halt;

  logic [15:0] mem [4096];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .irq(irq), .halt(halt)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // each vector: operand a, operand b, opcode, expected result
  localparam logic [51:0] VEC [6] = '{
    {16'h0023, 16'hFFE9, 4'h3, 16'h000C},
    {16'h7FFF, 16'h0001, 4'h3, 16'h8000},
    {16'h0000, 16'h0001, 4'h4, 16'hFFFF},
    {16'h8000, 16'h0001, 4'h4, 16'h7FFF},
    {16'h1234, 16'h4321, 4'h3, 16'h5555},
    {16'h0005, 16'h0005, 4'h4, 16'h0000}
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic prep();
    rst = 1'b1; irq = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 4096; a++) mem[a] <= 16'h0000;
  endtask

  task automatic put(logic [11:0] a, logic [15:0] v);
    mem[a] <= v;
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_halt(string tag);
    int n;
    n = 0;
    while (!halt && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " halt reached"}, {15'd0, halt}, 16'h0001);
  endtask

  task automatic skip_case(logic [15:0] v, logic [1:0] sel, bit exp_skip);
    prep();
    put(12'h010, 16'h1040);
    put(12'h011, {4'h8, sel, 10'h000});
    put(12'h012, 16'h1043);
    put(12'h013, 16'h2042);
    put(12'h014, 16'h7000);
    put(12'h040, v);
    put(12'h043, 16'h5A5A);
    release_rst();
    run_halt("R4");
    check("R4 skip result", mem[12'h042], exp_skip ? v : 16'h5A5A);
  endtask

  initial begin
    // R1: reset state
    prep();
    @(negedge clk);
    check("R1 halt low", {15'd0, halt}, 16'h0000);
    check("R1 we low", {15'd0, mem_we}, 16'h0000);
    check("R1 out_valid low", {15'd0, out_valid}, 16'h0000);
    check("R1 in_ready low", {15'd0, in_ready}, 16'h0000);
    put(12'h010, 16'h7000);
    release_rst();
    @(negedge clk);
    check("R1 first fetch address", {4'h0, mem_addr}, 16'h0010);
    run_halt("R1");

    // R2: vector table through load, add/subtract, store
    for (int i = 0; i < 6; i++) begin
      prep();
      put(12'h010, 16'h1040);
      put(12'h011, {VEC[i][19:16], 12'h041});
      put(12'h012, 16'h2042);
      put(12'h013, 16'h7000);
      put(12'h040, VEC[i][51:36]);
      put(12'h041, VEC[i][35:20]);
      release_rst();
      run_halt("R2");
      check("R2 arithmetic", mem[12'h042], VEC[i][15:0]);
    end

    // R4: skip conditions
    skip_case(16'hFFF0, 2'b00, 1'b1);
    skip_case(16'h0007, 2'b00, 1'b0);
    skip_case(16'h0000, 2'b01, 1'b1);
    skip_case(16'h0007, 2'b01, 1'b0);
    skip_case(16'h0007, 2'b10, 1'b1);
    skip_case(16'h0000, 2'b10, 1'b0);
    skip_case(16'hFFF0, 2'b10, 1'b0);
    skip_case(16'h0007, 2'b11, 1'b0);

    // R5: jump over a clear, then clear; R10: 0xD is a no-op
    prep();
    put(12'h010, 16'h1040);
    put(12'h011, 16'h9013);
    put(12'h012, 16'hA000);
    put(12'h013, 16'hD123);
    put(12'h014, 16'h2042);
    put(12'h015, 16'hA000);
    put(12'h016, 16'h2043);
    put(12'h017, 16'h7000);
    put(12'h040, 16'h3C3C);
    put(12'h043, 16'hFFFF);
    release_rst();
    run_halt("R5");
    check("R5/R10 jump skips clear, 0xD no-op", mem[12'h042], 16'h3C3C);
    check("R5 clear", mem[12'h043], 16'h0000);

    // R6: jump-and-save, return through pointer jump
    prep();
    put(12'h010, 16'h0020);
    put(12'h011, 16'h2041);
    put(12'h012, 16'h7000);
    put(12'h021, 16'h1040);
    put(12'h022, 16'hC020);
    put(12'h040, 16'hBEEF);
    release_rst();
    run_halt("R6");
    check("R6 return address saved", mem[12'h020], 16'h0011);
    check("R6 subroutine result", mem[12'h041], 16'hBEEF);

    // R7: add through a pointer
    prep();
    put(12'h010, 16'h1040);
    put(12'h011, 16'hB041);
    put(12'h012, 16'h2042);
    put(12'h013, 16'h7000);
    put(12'h040, 16'h0100);
    put(12'h041, 16'h0050);
    put(12'h050, 16'h0023);
    release_rst();
    run_halt("R7");
    check("R7 indirect add", mem[12'h042], 16'h0123);

    // R8 / R9: input then output handshakes
    prep();
    put(12'h010, 16'h5000);
    put(12'h011, 16'h6000);
    put(12'h012, 16'h2042);
    put(12'h013, 16'h7000);
    release_rst();
    begin
      int n;
      n = 0;
      while (!in_ready && n < 100) begin @(negedge clk); n++; end
      check("R8 in_ready raised", {15'd0, in_ready}, 16'h0001);
      repeat (3) @(negedge clk);
      check("R8 waits for in_valid", {15'd0, in_ready}, 16'h0001);
      in_data = 8'hA7; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; in_data = 8'h00;
      n = 0;
      while (!out_valid && n < 100) begin @(negedge clk); n++; end
      check("R9 out_valid raised", {15'd0, out_valid}, 16'h0001);
      check("R9 out_data", {8'h00, out_data}, 16'h00A7);
      repeat (4) @(negedge clk);
      check("R9 held without ready", {7'd0, out_valid, out_data}, 16'h01A7);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check("R9 dropped after ready", {15'd0, out_valid}, 16'h0000);
    end
    run_halt("R8");
    check("R8 zero-extended input", mem[12'h042], 16'h00A7);

    // R10: halt sticks and writes nothing
    begin
      int wr;
      wr = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (mem_we || !halt) wr++;
      end
      check("R10 stays halted, no writes", wr[15:0], 16'h0000);
    end

    // R11: interrupt at end of a taken skip, masked in handler
    prep();
    put(12'h001, 16'h1044);
    put(12'h002, 16'h2050);
    put(12'h003, 16'hC000);
    put(12'h010, 16'h8400);
    put(12'h011, 16'h7000);
    put(12'h012, 16'h1040);
    put(12'h013, 16'h2042);
    put(12'h014, 16'h7000);
    put(12'h040, 16'h1111);
    put(12'h044, 16'h00C5);
    irq = 1'b1;
    release_rst();
    begin
      int n;
      n = 0;
      while (!halt && n < 3000) begin
        @(negedge clk);
        if (mem_we && mem_addr == 12'h050) irq = 1'b0;
        n++;
      end
    end
    check("R11 halt reached", {15'd0, halt}, 16'h0001);
    check("R11 saved PC includes skip", mem[12'h000], 16'h0012);
    check("R11 handler ran", mem[12'h050], 16'h00C5);
    check("R11 main resumed", mem[12'h042], 16'h1111);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule